// File: doc/BRIEF.md
# TDM master frame timing generator

This block is the timing master of a serial time-division link that carries two bearer channels and one signalling channel (2B+D). It runs on a 20.48 MHz reference clock. From that clock it builds a data clock at one of three rates, a long-format frame sync that repeats every 2560 reference cycles (125 µs), and an active-low transmit-enable strobe. The strobe marks the bearer and signalling timeslots, either in an 8-bit frame layout or in a 10-bit frame layout.

A phase tracker outside this block can ask for the data clock to advance or retard, so that the clock follows a received line. The request is not applied at once. On each of two successive frames, one data-clock bit that lies past the data-transfer window gets a high phase one reference cycle shorter or longer than normal. The total correction is therefore two reference periods. All other bits keep an exact 50% duty cycle.

The rate select and format select are taken at reset and at each frame boundary. Changes made in the middle of a frame never distort the frame in progress.

Top module: `tdm_frame_timer`

## Requirements
- R1: While `rst_n` is low, `dclk` and `fsync` are 0 and `tsen_n` is 1. The first rising `clk` edge with `rst_n` high starts bit 0 of a new frame, so `dclk` and `fsync` become 1 and `tsen_n` becomes 0 at that edge.
- R2: `rate_sel` selects the bit length D in reference cycles: 0 gives 40 (512 kHz), 1 gives 10 (2.048 MHz), and 2 or 3 gives 8 (2.56 MHz). An unadjusted bit is high for D/2 cycles and then low for D/2 cycles.
- R3: With no adjustment, consecutive rising edges of `fsync` are 2560 reference cycles apart at every rate, which is 64, 256 or 320 bits.
- R4: `fsync` is high for exactly bits 0 to 7 of the frame. It rises and falls together with rising edges of `dclk`.
- R5: With `fmt10` = 0, `tsen_n` goes low at the start of bit 0. It returns high at the falling `dclk` edge inside bit 17, which covers B1 (bits 0-7), B2 (bits 8-15) and D (bits 16-17).
- R6: With `fmt10` = 1, `tsen_n` is low from the start of bit 0 until the falling edge inside bit 8 (B1 in bits 0-7, D in bit 8). It is low again from the start of bit 10 until the falling edge inside bit 18 (B2 in bits 10-17, D in bit 18). Bits 9 and 19 are framing bits and are never enabled.
- R7: A one-cycle `adj_req` pulse is accepted when no adjustment is pending. `adj_dir` = 1 shortens and 0 lengthens. The next two frames whose bit 20 starts after the request has been taken each have bit 20's high phase changed by one reference cycle, so those frames last 2559 or 2561 cycles.
- R8: A high phase that is not D/2 occurs only in bit 20, which is outside both transfer windows (bits 0-17 and bits 0-19). It never occurs inside the window.
- R9: An `adj_req` that arrives while an adjustment is pending is ignored. Neither its direction nor its count has any effect.
- R10: Once the second adjusted frame has started, the block accepts a new `adj_req` again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 20.48 MHz reference clock |
| rst_n | input | 1 | synchronous active-low reset |
| rate_sel | input | 2 | data clock rate select, sampled at each frame boundary |
| fmt10 | input | 1 | 1 selects the 10-bit frame layout, sampled at each frame boundary |
| adj_req | input | 1 | one-cycle request for a phase correction |
| adj_dir | input | 1 | correction direction: 1 advances (shorter high phase), 0 retards |
| dclk | output | 1 | data clock |
| fsync | output | 1 | long frame sync, eight bits wide |
| tsen_n | output | 1 | active-low transmit enable for the B1, B2 and D timeslots |

## Verification
Some properties are checked on every cycle. A bit always ends with the data clock low. The strobe is never active past bit 19. Sync edges fall exactly on bit boundaries 0 and 8. An adjusted bit is always bit 20. A request made while a correction is pending leaves the stored direction untouched. Other behaviour only shows over whole frames: that the correction lands on exactly two consecutive frames, that the ignored request really has no effect, that the frame period follows 2560 plus the applied slips, and that rate and format changes wait for a frame boundary. The directed and random scenarios cover these frame-level behaviours.

// File: rtl/tfg_pkg.sv
`timescale 1ns/1ps
package tfg_pkg;

   // Adjustment applied to the high phase of one data-clock bit
   typedef enum logic [1:0] {
      ADJ_NONE  = 2'd0,
      ADJ_SHORT = 2'd1,
      ADJ_LONG  = 2'd2
   } adj_e;

   // Widest transfer window over both layouts, in bits
   localparam int unsigned SLOT_SPAN = 20;

   // Transmit slots: 8-bit layout B1,B2,D packed; 10-bit layout B1,D,F,B2,D,F
   function automatic logic slot_on(input logic fmt10, input int b);
      if (fmt10) return (b >= 0 && b <= 8) || (b >= 10 && b <= 18);
      return b >= 0 && b <= 17;
   endfunction

endpackage

// File: rtl/tfg_slip.sv
`timescale 1ns/1ps
module tfg_slip
   import tfg_pkg::*;
#(
   parameter int unsigned SLIP_FRAMES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic adj_req,
   input  logic adj_dir,
   input  logic take,
   output logic pending,
   output adj_e kind
);
   localparam int unsigned CNT_W = $clog2(SLIP_FRAMES + 1);

   logic [CNT_W-1:0] left_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pending <= 1'b0;
         left_q  <= '0;
         kind    <= ADJ_NONE;
      end else if (take) begin
         left_q <= left_q - CNT_W'(1);
         if (left_q == CNT_W'(1)) begin
            pending <= 1'b0;
            kind    <= ADJ_NONE;
         end
      end else if (adj_req && !pending) begin
         pending <= 1'b1;
         left_q  <= CNT_W'(SLIP_FRAMES);
         kind    <= adj_dir ? ADJ_SHORT : ADJ_LONG;
      end
   end

   assert_busy_req_dropped_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (pending && adj_req && !take) |=> (pending && $stable(kind)));

   assert_pending_from_req_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pending) |-> $past(adj_req));

   assert_take_needs_pending_R10: assert property (@(posedge clk) disable iff (!rst_n)
      take |-> pending);

endmodule

// File: rtl/tfg_bitclk.sv
`timescale 1ns/1ps
module tfg_bitclk
   import tfg_pkg::*;
#(
   parameter int unsigned PH_W = 6
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [PH_W-1:0] div,
   input  adj_e            next_adj,
   output logic            dclk,
   output logic            bit_end,
   output adj_e            cur_adj
);
   logic            live_q;
   logic [PH_W-1:0] ph_q;
   logic [PH_W-1:0] half, hi_len, bit_len;
   adj_e            adj_q;

   always_comb begin
      half = div >> 1;
      case (adj_q)
         ADJ_SHORT: begin
            hi_len  = half - PH_W'(1);
            bit_len = div - PH_W'(1);
         end
         ADJ_LONG: begin
            hi_len  = half + PH_W'(1);
            bit_len = div + PH_W'(1);
         end
         default: begin
            hi_len  = half;
            bit_len = div;
         end
      endcase
   end

   assign bit_end = !live_q || (ph_q == bit_len - PH_W'(1));
   assign dclk    = live_q && (ph_q < hi_len);
   assign cur_adj = adj_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         live_q <= 1'b0;
         ph_q   <= '0;
         adj_q  <= ADJ_NONE;
      end else if (bit_end) begin
         live_q <= 1'b1;
         ph_q   <= '0;
         adj_q  <= next_adj;
      end else begin
         ph_q <= ph_q + PH_W'(1);
      end
   end

   assert_bit_ends_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (live_q && bit_end) |-> !dclk);

   assert_bit_starts_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (live_q && $past(bit_end)) |-> dclk);

endmodule

// File: rtl/tfg_framer.sv
`timescale 1ns/1ps
module tfg_framer
   import tfg_pkg::*;
#(
   parameter int unsigned FRAME_REF = 2560,
   parameter int unsigned DIV_SLOW  = 40,
   parameter int unsigned DIV_MID   = 10,
   parameter int unsigned DIV_FAST  = 8,
   parameter int unsigned SYNC_BITS = 8,
   parameter int unsigned SLIP_BIT  = 20,
   parameter int unsigned PH_W      = 6,
   parameter int unsigned BIT_W     = 9
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [1:0]       rate_sel,
   input  logic             fmt10,
   input  logic             bit_end,
   input  logic             dclk,
   output logic [PH_W-1:0]  div,
   output logic [BIT_W-1:0] bit_idx,
   output logic             slip_next,
   output logic             fsync,
   output logic             tsen_n
);
   localparam logic [BIT_W-1:0] LAST_SLOW = BIT_W'(FRAME_REF / DIV_SLOW - 1);
   localparam logic [BIT_W-1:0] LAST_MID  = BIT_W'(FRAME_REF / DIV_MID - 1);
   localparam logic [BIT_W-1:0] LAST_FAST = BIT_W'(FRAME_REF / DIV_FAST - 1);

   function automatic logic [BIT_W-1:0] last_of(input logic [1:0] r);
      case (r)
         2'd0:    return LAST_SLOW;
         2'd1:    return LAST_MID;
         default: return LAST_FAST;
      endcase
   endfunction

   logic [1:0]       rate_q;
   logic             fmt_q;
   logic [BIT_W-1:0] idx_q, nxt;
   logic             wrap, on_now, on_next;

   always_comb begin
      case (rate_q)
         2'd0:    div = PH_W'(DIV_SLOW);
         2'd1:    div = PH_W'(DIV_MID);
         default: div = PH_W'(DIV_FAST);
      endcase
      wrap    = (idx_q == last_of(rate_q));
      nxt     = wrap ? '0 : idx_q + BIT_W'(1);
      on_now  = slot_on(fmt_q, int'(idx_q));
      on_next = slot_on(fmt_q, int'(idx_q) + 1);
   end

   assign slip_next = bit_end && (nxt == BIT_W'(SLIP_BIT));
   assign fsync     = idx_q < BIT_W'(SYNC_BITS);
   assign tsen_n    = !(on_now && (dclk || on_next));
   assign bit_idx   = idx_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rate_q <= rate_sel;
         fmt_q  <= fmt10;
         idx_q  <= last_of(rate_sel);
      end else if (bit_end) begin
         idx_q <= nxt;
         if (wrap) begin
            rate_q <= rate_sel;
            fmt_q  <= fmt10;
         end
      end
   end

   assert_strobe_in_window_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !tsen_n |-> (idx_q < BIT_W'(SLOT_SPAN)));

   assert_sync_rise_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(fsync) |-> (idx_q == '0) && $past(bit_end));

   assert_sync_fall_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(fsync) |-> (idx_q == BIT_W'(SYNC_BITS)) && $past(bit_end));

   assert_framing_bit_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (fmt_q && (idx_q == BIT_W'(9))) |-> tsen_n);

endmodule

// File: rtl/tdm_frame_timer.sv
`timescale 1ns/1ps
module tdm_frame_timer
   import tfg_pkg::*;
#(
   parameter int unsigned FRAME_REF   = 2560,
   parameter int unsigned DIV_SLOW    = 40,
   parameter int unsigned DIV_MID     = 10,
   parameter int unsigned DIV_FAST    = 8,
   parameter int unsigned SYNC_BITS   = 8,
   parameter int unsigned SLIP_BIT    = 20,
   parameter int unsigned SLIP_FRAMES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [1:0] rate_sel,
   input  logic       fmt10,
   input  logic       adj_req,
   input  logic       adj_dir,
   output logic       dclk,
   output logic       fsync,
   output logic       tsen_n
);
   localparam int unsigned PH_W     = $clog2(DIV_SLOW + 2);
   localparam int unsigned MAX_BITS = FRAME_REF / DIV_FAST;
   localparam int unsigned MIN_BITS = FRAME_REF / DIV_SLOW;
   localparam int unsigned BIT_W    = $clog2(MAX_BITS);

   // Elaboration-time parameter checks
   if ((DIV_SLOW % 2) != 0 || (DIV_MID % 2) != 0 || (DIV_FAST % 2) != 0) begin : g_odd_div
      $error("divide ratios must be even");
   end
   if (DIV_FAST < 4 || DIV_MID < DIV_FAST || DIV_SLOW < DIV_MID) begin : g_div_order
      $error("divide ratios must be ordered and at least 4");
   end
   if ((FRAME_REF % DIV_SLOW) != 0 || (FRAME_REF % DIV_MID) != 0 ||
       (FRAME_REF % DIV_FAST) != 0) begin : g_frame_fit
      $error("frame length must be a whole number of bits at every rate");
   end
   if (SLIP_BIT < SLOT_SPAN || SLIP_BIT >= MIN_BITS) begin : g_slip_pos
      $error("slip bit must lie after the transfer window and inside the frame");
   end
   if (SYNC_BITS == 0 || SYNC_BITS >= MIN_BITS || SLIP_FRAMES == 0) begin : g_misc
      $error("sync width or slip count out of range");
   end

   logic [PH_W-1:0]  div;
   logic [BIT_W-1:0] bit_idx;
   logic             bit_end, slip_next, pending, take;
   adj_e             kind, next_adj, cur_adj;

   assign take     = slip_next && pending;
   assign next_adj = take ? kind : ADJ_NONE;

   tfg_slip #(.SLIP_FRAMES(SLIP_FRAMES)) u_slip (
      .clk(clk), .rst_n(rst_n), .adj_req(adj_req), .adj_dir(adj_dir),
      .take(take), .pending(pending), .kind(kind)
   );

   tfg_bitclk #(.PH_W(PH_W)) u_bitclk (
      .clk(clk), .rst_n(rst_n), .div(div), .next_adj(next_adj),
      .dclk(dclk), .bit_end(bit_end), .cur_adj(cur_adj)
   );

   tfg_framer #(
      .FRAME_REF(FRAME_REF), .DIV_SLOW(DIV_SLOW), .DIV_MID(DIV_MID),
      .DIV_FAST(DIV_FAST), .SYNC_BITS(SYNC_BITS), .SLIP_BIT(SLIP_BIT),
      .PH_W(PH_W), .BIT_W(BIT_W)
   ) u_framer (
      .clk(clk), .rst_n(rst_n), .rate_sel(rate_sel), .fmt10(fmt10),
      .bit_end(bit_end), .dclk(dclk), .div(div), .bit_idx(bit_idx),
      .slip_next(slip_next), .fsync(fsync), .tsen_n(tsen_n)
   );

   assert_slip_outside_window_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (cur_adj != ADJ_NONE) |-> (bit_idx == BIT_W'(SLIP_BIT)));

   assert_no_strobe_on_slip_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (cur_adj != ADJ_NONE) |-> tsen_n);

endmodule

// File: tb/tdm_frame_timer_tb.sv
`timescale 1ns/1ps
module tdm_frame_timer_tb;
   localparam int FR = 2560;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [1:0] rate_sel = 2'd1;
   logic fmt10 = 1'b0, adj_req = 1'b0, adj_dir = 1'b0;
   logic dclk, fsync, tsen_n;

   always #2.5 clk = ~clk;

   tdm_frame_timer u_dut (
      .clk(clk), .rst_n(rst_n), .rate_sel(rate_sel), .fmt10(fmt10),
      .adj_req(adj_req), .adj_dir(adj_dir),
      .dclk(dclk), .fsync(fsync), .tsen_n(tsen_n)
   );

   int vec = 0, bad = 0, cyc = 0;
   bit done = 0;

   function automatic int div_of(input logic [1:0] r);
      return (r == 2'd0) ? 40 : (r == 2'd1) ? 10 : 8;
   endfunction

   function automatic bit slot(input bit f, input int b);
      if (f) return (b <= 8) || (b >= 10 && b <= 18);
      return b <= 17;
   endfunction

   task automatic chk(input string tag, input int act, input int exp);
      vec++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d cycle=%0d", tag, act, exp, cyc);
      end
   endtask

   // Reference model: bit timeline of the requirements, stepped per reference cycle
   bit m_live, m_fmt, m_pend, m_dir;
   int m_ph, m_bit, m_div, m_adj, m_left, m_acc, m_last_adj;
   int s_len, s_nb, s_nx;
   bit s_end, s_take;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_live = 0; m_ph = 0; m_div = div_of(rate_sel); m_fmt = fmt10;
         m_bit = FR / m_div - 1; m_adj = 0; m_pend = 0; m_left = 0; m_dir = 0;
         m_acc = 0; m_last_adj = 0;
      end else begin
         s_len  = m_div + m_adj;
         s_end  = !m_live || (m_ph == s_len - 1);
         s_nb   = FR / m_div;
         s_nx   = (m_bit == s_nb - 1) ? 0 : m_bit + 1;
         s_take = s_end && m_pend && (s_nx == 20);
         if (s_end) begin
            if (m_bit == s_nb - 1) begin
               m_div = div_of(rate_sel); m_fmt = fmt10;
               m_last_adj = m_acc; m_acc = 0;
            end
            m_bit = s_nx; m_ph = 0; m_live = 1;
            m_adj = s_take ? (m_dir ? -1 : 1) : 0;
            m_acc += m_adj;
         end else begin
            m_ph++;
         end
         if (s_take) begin
            m_left--;
            if (m_left == 0) m_pend = 0;
         end else if (adj_req && !m_pend) begin
            m_pend = 1; m_left = 2; m_dir = adj_dir;
         end
      end
   end

   // Observation state
   bit fs_prev, dc_prev, have_prev;
   int last_rise, nrise, hi_run, obs_bit;
   int rise_t [0:8];

   task automatic tick();
      bit e_dclk, e_fs, e_ts;
      @(negedge clk);
      cyc++;
      e_dclk = m_live && (m_ph < m_div / 2 + m_adj);
      e_fs   = m_live && (m_bit < 8);
      e_ts   = !(m_live && slot(m_fmt, m_bit) && (e_dclk || slot(m_fmt, m_bit + 1)));
      chk((m_adj != 0) ? "R7 dclk" : "R2 dclk", int'(dclk), int'(e_dclk));
      chk("R4 fsync", int'(fsync), int'(e_fs));
      chk(m_fmt ? "R6 tsen_n" : "R5 tsen_n", int'(tsen_n), int'(e_ts));
      if (!rst_n) begin
         have_prev = 0; nrise = 0; hi_run = 0; obs_bit = 0;
      end else begin
         if (dclk && !dc_prev) begin
            obs_bit = (fsync && !fs_prev) ? 0 : obs_bit + 1;
            hi_run = 0;
         end
         if (dclk) hi_run++;
         if (!dclk && dc_prev && hi_run != m_div / 2)
            chk("R8 odd high phase bit", obs_bit, 20);
         if (fsync && !fs_prev) begin
            if (have_prev) chk("R3 frame period", cyc - last_rise, FR + m_last_adj);
            last_rise = cyc; have_prev = 1;
            if (nrise <= 8) rise_t[nrise] = cyc;
            nrise++;
         end
      end
      fs_prev = fsync; dc_prev = dclk;
   endtask

   task automatic run(input int n);
      for (int i = 0; i < n; i++) tick();
   endtask

   task automatic pulse_req(input bit dir);
      adj_req = 1'b1; adj_dir = dir;
      tick();
      adj_req = 1'b0;
   endtask

   task automatic wait_rises(input int n);
      for (int i = 0; i < 6 * FR && nrise < n; i++) tick();
   endtask

   initial begin
      #(5.0 * 190000);
      if (!done) begin
         bad++;
         $display("FAIL watchdog expired at cycle %0d", cyc);
         $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20480));
      // Directed: reset state and start of first frame
      rate_sel = 2'd1; fmt10 = 1'b0; rst_n = 1'b0;
      run(3);
      chk("R1 reset dclk", int'(dclk), 0);
      chk("R1 reset fsync", int'(fsync), 0);
      chk("R1 reset tsen_n", int'(tsen_n), 1);
      rst_n = 1'b1;
      tick();
      chk("R1 first dclk", int'(dclk), 1);
      chk("R1 first fsync", int'(fsync), 1);
      chk("R1 first tsen_n", int'(tsen_n), 0);
      // Directed: advance request, ignored retard while pending, then a fresh retard
      run(299);
      pulse_req(1'b1);
      run(FR);
      pulse_req(1'b0);
      wait_rises(5);
      chk("R3 unadjusted frame", rise_t[1] - rise_t[0], 2560);
      chk("R7 first shortened frame", rise_t[2] - rise_t[1], 2559);
      chk("R9 second frame keeps direction", rise_t[3] - rise_t[2], 2559);
      chk("R10 third frame unadjusted", rise_t[4] - rise_t[3], 2560);
      pulse_req(1'b0);
      wait_rises(8);
      chk("R10 new request lengthens", rise_t[5] - rise_t[4], 2561);
      chk("R10 second lengthened frame", rise_t[6] - rise_t[5], 2561);
      chk("R10 back to nominal", rise_t[7] - rise_t[6], 2560);
      // Random segments: rates, layouts, mid-frame config changes, random requests
      for (int seg = 0; seg < 8; seg++) begin
         rst_n = 1'b0;
         rate_sel = 2'($urandom % 4); fmt10 = 1'($urandom % 2);
         run(2);
         rst_n = 1'b1;
         for (int c = 0; c < 3 * FR; c++) begin
            if (($urandom % 1200) == 0) begin
               rate_sel = 2'($urandom % 4); fmt10 = 1'($urandom % 2);
            end
            if (($urandom % 900) == 0) pulse_req(1'($urandom % 2));
            else tick();
         end
      end
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
      $finish;
   end
endmodule